// File: doc/BRIEF.md
# Command-Driven Programmable Interval Timer

A 16-bit interval timer configured entirely through self-clearing command codes written to a control address on a small byte-wide register bus. Two further addresses hold the low and high bytes of the terminal count N. The timer runs in one of two modes. In one-shot mode it produces a single high-to-low timeout. In re-triggerable mode it produces a free-running square wave. It counts single-cycle tick enables taken from either an internal oscillator tick or an external tick input.

The timer output can be routed to a general-purpose pin. An interrupt line rises when the interrupt is enabled and a timeout or falling edge is pending. Reading the control address reports that pending status and clears it. While the timer runs, the count bytes and every configuration command are locked. Only start, stop and reset get through.

Top module: `cmd_interval_timer`

## Requirements
- R1: After hardware reset, tmr_o is 1, pin_o is 0 and irq_o is 0. The mode is re-triggerable, the source is the internal tick, the interrupt is disabled, the output is not routed, the timer is stopped, and both count bytes read 0x00.
- R2: A write to address 0 decodes only wdata_i[3:0], and wdata_i[7:4] is ignored. The command codes are: 1 = interrupt on, 2 = interrupt off, 3 = one-shot, 4 = re-triggerable, 5 = internal source, 6 = external source, 7 = route on, 8 = route off, 9 = start, 10 = stop, 11 = reset. Codes 0 and 12 to 15 change nothing.
- R3: A read of address 0 returns 0x01 when the interrupt is enabled and pending, and 0x00 otherwise. The read clears the pending flag. irq_o is 1 exactly when the interrupt is enabled and pending.
- R4: In one-shot mode, tmr_o stays 1 after start through N-1 source ticks. It goes to 0 on the Nth tick, stays 0, and sets the pending flag.
- R5: In one-shot mode, a start before timeout restarts a full N-tick period. A start after timeout has no effect. A stop returns tmr_o to 1.
- R6: In re-triggerable mode, tmr_o is 1 for Q ticks and then 0 for P ticks, repeating, where P = floor(N/2) and Q = N - P. Each 1-to-0 transition sets the pending flag.
- R7: The counter advances only on a tick of the selected source (osc_tick_i for internal, ext_tick_i for external). Ticks on the other input are ignored.
- R8: While running, writes to addresses 1 and 2 are discarded, and all commands other than start, stop and reset are discarded.
- R9: pin_o equals tmr_o when routed and is 0 otherwise.
- R10: The reset command restores the R1 configuration, stops the timer and clears the pending flag, while keeping N. A stop also clears the pending flag. Reads of address 1 and 2 return the low and high bytes of N, and a read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read of address 0 clears pending) |
| addr_i | input | 2 | Register address: 0 control, 1 count low, 2 count high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| osc_tick_i | input | 1 | Internal oscillator tick enable |
| ext_tick_i | input | 1 | External clock tick enable |
| tmr_o | output | 1 | Timer output |
| pin_o | output | 1 | Routed timer output to the general-purpose pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 16-bit count and 8-bit bus. It programs small terminal counts (2, 4 and 5), so every phase boundary, the odd and even P/Q splits and the minimum legal count fall within a few ticks. Small counts also make it possible to observe one-shot timeouts, re-triggered periods, source switching and the run-time lockouts cycle by cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [3:0] {
    CMD_NOP       = 4'd0,
    CMD_IRQ_ON    = 4'd1,
    CMD_IRQ_OFF   = 4'd2,
    CMD_ONESHOT   = 4'd3,
    CMD_RETRIG    = 4'd4,
    CMD_SRC_INT   = 4'd5,
    CMD_SRC_EXT   = 4'd6,
    CMD_ROUTE_ON  = 4'd7,
    CMD_ROUTE_OFF = 4'd8,
    CMD_START     = 4'd9,
    CMD_STOP      = 4'd10,
    CMD_RESET     = 4'd11
  } tmr_cmd_e;
endpackage

// File: rtl/timer_regs.sv
module timer_regs import timer_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              status_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  n_o,
  output logic              oneshot_o,
  output logic              src_ext_o,
  output logic              route_o,
  output logic              irq_en_o,
  output logic              run_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              ctrl_rd_o
);
  localparam int NB = CNT_W / DATA_W;

  logic       ctrl_wr, cmd_start, cmd_stop, cmd_reset, cfg_ok;
  logic [3:0] cmd;
  logic       run_q, oneshot_q, src_ext_q, route_q, irq_en_q;
  logic [CNT_W-1:0] n_q;

  assign ctrl_wr   = wr_en_i && (addr_i == '0);
  assign cmd       = wdata_i[3:0];
  assign cmd_start = ctrl_wr && (cmd == CMD_START);
  assign cmd_stop  = ctrl_wr && (cmd == CMD_STOP);
  assign cmd_reset = ctrl_wr && (cmd == CMD_RESET);
  assign cfg_ok    = ctrl_wr && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || cmd_reset) begin
      run_q <= 1'b0; oneshot_q <= 1'b0; src_ext_q <= 1'b0;
      route_q <= 1'b0; irq_en_q <= 1'b0;
    end else begin
      if (cmd_stop)       run_q <= 1'b0;
      else if (cmd_start) run_q <= 1'b1;
      if (cfg_ok) begin
        case (cmd)
          CMD_IRQ_ON:    irq_en_q  <= 1'b1;
          CMD_IRQ_OFF:   irq_en_q  <= 1'b0;
          CMD_ONESHOT:   oneshot_q <= 1'b1;
          CMD_RETRIG:    oneshot_q <= 1'b0;
          CMD_SRC_INT:   src_ext_q <= 1'b0;
          CMD_SRC_EXT:   src_ext_q <= 1'b1;
          CMD_ROUTE_ON:  route_q   <= 1'b1;
          CMD_ROUTE_OFF: route_q   <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) n_q[b*DATA_W +: DATA_W] <= '0;
      else if (wr_en_i && !run_q && addr_i == ADDR_W'(b + 1))
        n_q[b*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o[0] = status_i;
    for (int b = 0; b < NB; b++)
      if (addr_i == ADDR_W'(b + 1)) rdata_o = n_q[b*DATA_W +: DATA_W];
  end

  assign n_o       = n_q;
  assign oneshot_o = oneshot_q;
  assign src_ext_o = src_ext_q;
  assign route_o   = route_q;
  assign irq_en_o  = irq_en_q;
  assign run_o     = run_q;
  assign start_o   = cmd_start;
  assign stop_o    = cmd_stop || cmd_reset;
  assign ctrl_rd_o = rd_en_i && (addr_i == '0);

  // R8
  n_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> $stable(n_q));
  // R8
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !stop_o) |=> $stable({oneshot_q, src_ext_q, route_q, irq_en_q}));
  // R2
  reserved_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && cmd >= 4'd12) |=> $stable({run_q, oneshot_q, src_ext_q, route_q, irq_en_q}));
endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] n_i,
  input  logic             oneshot_i,
  input  logic             src_ext_i,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             osc_tick_i,
  input  logic             ext_tick_i,
  output logic             out_o,
  output logic             fall_o
);
  logic             tick;
  logic [CNT_W-1:0] p_len, q_len, lim;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d, done_q, done_d;

  assign tick  = src_ext_i ? ext_tick_i : osc_tick_i;
  assign p_len = n_i >> 1;
  assign q_len = n_i - p_len;
  assign lim   = oneshot_i ? n_i : (out_q ? q_len : p_len);

  always_comb begin
    cnt_d = cnt_q; out_d = out_q; done_d = done_q;
    if (stop_i) begin
      cnt_d = '0; out_d = 1'b1; done_d = 1'b0;
    end else if (start_i && !done_q) begin
      cnt_d = '0; out_d = 1'b1;
    end else if (run_i && tick && !done_q) begin
      if (cnt_q == lim - CNT_W'(1)) begin
        cnt_d = '0;
        if (oneshot_i) begin out_d = 1'b0; done_d = 1'b1; end
        else out_d = !out_q;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; out_q <= 1'b1; done_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d; out_q <= out_d; done_q <= done_d;
    end
  end

  assign out_o  = out_q;
  assign fall_o = out_q && !out_d;

  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !stop_i) |=> (done_q && !out_q));
  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> out_q);
  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && n_i >= CNT_W'(2)) |-> cnt_q < n_i);
  // R7
  fall_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> tick);
endmodule

// File: rtl/cmd_interval_timer.sv
module cmd_interval_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(CNT_W / DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              osc_tick_i,
  input  logic              ext_tick_i,
  output logic              tmr_o,
  output logic              pin_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] n;
  logic oneshot, src_ext, route, irq_en, run, start, stop, ctrl_rd;
  logic out, fall, pend_q;

  timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .status_i(irq_en && pend_q), .rdata_o,
    .n_o(n), .oneshot_o(oneshot), .src_ext_o(src_ext), .route_o(route),
    .irq_en_o(irq_en), .run_o(run), .start_o(start), .stop_o(stop),
    .ctrl_rd_o(ctrl_rd)
  );

  timer_core #(.CNT_W(CNT_W)) i_core (
    .clk_i, .rst_ni, .n_i(n), .oneshot_i(oneshot), .src_ext_i(src_ext),
    .run_i(run), .start_i(start), .stop_i(stop),
    .osc_tick_i, .ext_tick_i, .out_o(out), .fall_o(fall)
  );

  // set wins over a same-cycle read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (fall)            pend_q <= 1'b1;
    else if (stop || ctrl_rd) pend_q <= 1'b0;
  end

  assign tmr_o = out;
  assign pin_o = route && out;
  assign irq_o = irq_en && pend_q;

  // R3
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd && !fall) |=> !pend_q);
  // R6
  fall_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> pend_q);
endmodule

// File: tb/test_cmd_interval_timer.sv
`timescale 1ns/1ps
module test_cmd_interval_timer;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_OT = 2'd2, K_ET = 2'd3;
  // {kind, addr, data, tmr, pin, irq, chk_rd, exp_rd}
  localparam int NV = 45;
  localparam logic [23:0] VEC [NV] = '{
    {K_WR,2'd1,8'h05,3'b100,1'b0,8'h00}, // 0 N lo
    {K_WR,2'd2,8'h00,3'b100,1'b0,8'h00},
    {K_WR,2'd0,8'h03,3'b100,1'b0,8'h00}, // one-shot
    {K_WR,2'd0,8'h01,3'b100,1'b0,8'h00}, // irq on
    {K_WR,2'd0,8'h07,3'b110,1'b0,8'h00}, // R9 route
    {K_WR,2'd0,8'h09,3'b110,1'b0,8'h00}, // start
    {K_OT,2'd0,8'h00,3'b110,1'b0,8'h00}, // R4 ticks 1..4 high
    {K_OT,2'd0,8'h00,3'b110,1'b0,8'h00},
    {K_OT,2'd0,8'h00,3'b110,1'b0,8'h00},
    {K_OT,2'd0,8'h00,3'b110,1'b0,8'h00},
    {K_OT,2'd0,8'h00,3'b001,1'b0,8'h00}, // R4 timeout
    {K_RD,2'd0,8'h00,3'b000,1'b1,8'h01}, // R3 status, clears
    {K_RD,2'd0,8'h00,3'b000,1'b1,8'h00},
    {K_WR,2'd0,8'h09,3'b000,1'b0,8'h00}, // R5 start after timeout ignored
    {K_OT,2'd0,8'h00,3'b000,1'b0,8'h00},
    {K_WR,2'd1,8'h07,3'b000,1'b0,8'h00}, // R8 blocked
    {K_RD,2'd1,8'h00,3'b000,1'b1,8'h05},
    {K_WR,2'd0,8'h0A,3'b110,1'b0,8'h00}, // R5 stop -> high
    {K_WR,2'd0,8'h04,3'b110,1'b0,8'h00}, // retrig
    {K_WR,2'd0,8'h06,3'b110,1'b0,8'h00}, // ext source
    {K_WR,2'd0,8'h09,3'b110,1'b0,8'h00}, // start
    {K_OT,2'd0,8'h00,3'b110,1'b0,8'h00}, // R7 ignored
    {K_ET,2'd0,8'h00,3'b110,1'b0,8'h00},
    {K_ET,2'd0,8'h00,3'b110,1'b0,8'h00},
    {K_ET,2'd0,8'h00,3'b001,1'b0,8'h00}, // R6 Q=3
    {K_ET,2'd0,8'h00,3'b001,1'b0,8'h00},
    {K_ET,2'd0,8'h00,3'b111,1'b0,8'h00}, // R6 P=2
    {K_RD,2'd0,8'h00,3'b110,1'b1,8'h01},
    {K_WR,2'd0,8'h02,3'b110,1'b0,8'h00}, // R8 irq-off ignored
    {K_ET,2'd0,8'h00,3'b110,1'b0,8'h00},
    {K_ET,2'd0,8'h00,3'b110,1'b0,8'h00},
    {K_ET,2'd0,8'h00,3'b001,1'b0,8'h00},
    {K_WR,2'd0,8'h08,3'b001,1'b0,8'h00}, // R8 unroute ignored
    {K_WR,2'd0,8'h0B,3'b100,1'b0,8'h00}, // R10 reset cmd
    {K_RD,2'd1,8'h00,3'b100,1'b1,8'h05}, // R10 N kept
    {K_WR,2'd0,8'h09,3'b100,1'b0,8'h00}, // start: retrig, internal
    {K_ET,2'd0,8'h00,3'b100,1'b0,8'h00}, // R7 ignored
    {K_OT,2'd0,8'h00,3'b100,1'b0,8'h00},
    {K_OT,2'd0,8'h00,3'b100,1'b0,8'h00},
    {K_OT,2'd0,8'h00,3'b000,1'b0,8'h00}, // irq disabled
    {K_RD,2'd0,8'h00,3'b000,1'b1,8'h00}, // R3
    {K_WR,2'd0,8'h0A,3'b100,1'b0,8'h00},
    {K_WR,2'd0,8'h0C,3'b100,1'b0,8'h00}, // R2 reserved
    {K_WR,2'd0,8'h0F,3'b100,1'b0,8'h00},
    {K_RD,2'd3,8'h00,3'b100,1'b1,8'h00}  // R10 unused addr
  };

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, osc_tick = 1'b0, ext_tick = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       tmr, pin, irq;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] rd;

  always #10 clk = !clk;

  cmd_interval_timer i_cmd_interval_timer (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .osc_tick_i(osc_tick),
    .ext_tick_i(ext_tick), .tmr_o(tmr), .pin_o(pin), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] k, input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d;
    wr_en = (k == K_WR); rd_en = (k == K_RD);
    osc_tick = (k == K_OT); ext_tick = (k == K_ET);
    #5 rd = rdata;
    @(negedge clk);
    wr_en = 0; rd_en = 0; osc_tick = 0; ext_tick = 0;
  endtask

  function automatic logic [7:0] outs();
    return {5'd0, tmr, pin, irq};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", outs(), 8'b100);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23:22], VEC[i][21:20], VEC[i][19:12]);
      chk($sformatf("vec %0d outputs (R2-R10)", i), outs(), {5'd0, VEC[i][11:9]});
      if (VEC[i][8]) chk($sformatf("vec %0d rdata (R3 R8 R10)", i), rd, VEC[i][7:0]);
    end

    // R1 hardware reset mid-operation
    step(K_WR, 2'd0, 8'h07); step(K_WR, 2'd0, 8'h09);
    rst_ni = 1'b0; #2;
    chk("R1 async reset outputs", outs(), 8'b100);
    rst_ni = 1'b1;
    @(negedge clk);
    step(K_RD, 2'd1, 8'h00); chk("R1 count lo after reset", rd, 8'h00);
    step(K_RD, 2'd0, 8'h00); chk("R1 status after reset", rd, 8'h00);

    // R5 restart before timeout, N=2 boundary
    step(K_WR, 2'd1, 8'h02); step(K_WR, 2'd0, 8'h03); step(K_WR, 2'd0, 8'h09);
    step(K_OT, 2'd0, 8'h00); chk("R4 N=2 first tick high", outs(), 8'b100);
    step(K_WR, 2'd0, 8'h09);
    step(K_OT, 2'd0, 8'h00); chk("R5 restart keeps high", outs(), 8'b100);
    step(K_OT, 2'd0, 8'h00); chk("R4 N=2 timeout", outs(), 8'b000);
    step(K_WR, 2'd0, 8'h0A); chk("R5 stop high", outs(), 8'b100);

    // R2 upper nibble ignored: 0xF9 decodes as start
    step(K_WR, 2'd0, 8'hF9);
    step(K_OT, 2'd0, 8'h00); step(K_OT, 2'd0, 8'h00);
    chk("R2 upper bits ignored", outs(), 8'b000);
    step(K_WR, 2'd0, 8'h0A);

    // R6 even N=4: P=Q=2
    step(K_WR, 2'd1, 8'h04); step(K_WR, 2'd0, 8'h04); step(K_WR, 2'd0, 8'h09);
    step(K_OT, 2'd0, 8'h00); chk("R6 even tick1", {7'd0, tmr}, 8'd1);
    step(K_OT, 2'd0, 8'h00); chk("R6 even tick2", {7'd0, tmr}, 8'd0);
    step(K_OT, 2'd0, 8'h00); chk("R6 even tick3", {7'd0, tmr}, 8'd0);
    step(K_OT, 2'd0, 8'h00); chk("R6 even tick4", {7'd0, tmr}, 8'd1);
    step(K_WR, 2'd0, 8'h0A);

    // R2 reserved codes leave re-triggerable mode in place
    step(K_WR, 2'd0, 8'h0C); step(K_WR, 2'd0, 8'h0E); step(K_WR, 2'd0, 8'h09);
    for (int t = 0; t < 4; t++) step(K_OT, 2'd0, 8'h00);
    chk("R2 reserved no mode change", {7'd0, tmr}, 8'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule